// File: doc/BRIEF.md
# Memory-Backed Multi-Tap Delay Line

This block delays a stream of W-bit words through N equal stages of M words each, storing the words in memory lanes addressed by one shared circular pointer instead of a long chain of flip-flops. Every accepted word advances all stages at once. All N stage outputs (taps) are presented side by side on one wide bus, and the deepest tap is also brought out separately as the tail word.

Each shift reads the oldest entry of every lane at the pointer position and overwrites that entry with a new word. Lane 0 takes the incoming word. Every later lane takes the word that the lane before it has just read. The words read are registered into the tap outputs.

Input follows a valid-only stream rule. A word is taken on every rising clock edge where `in_valid` is high. The block has no ready signal and never applies back-pressure. While `in_valid` is low, nothing inside the block moves. A longer line is built outside the block by feeding `tail_data` of one instance into `in_data` of the next, with both instances driven by the same `in_valid`.

Top module: `mem_tap_shifter`

## Requirements
- R1: An accepted word is one sampled on a rising edge with `in_valid` high, and every such word is accepted. Count accepted words from 0 after reset. After word s is accepted, tap k (k = 1..N, in bits [k*W-1:(k-1)*W] of `tap_bus`, tap 1 in the lowest bits) equals word s-k*M. This holds whenever s >= k*M.
- R2: `tail_data` always equals tap N, the top W bits of `tap_bus`.
- R3: On a clock edge with `in_valid` low, `tap_bus` and `tail_data` keep their values.
- R4: Idle cycles between accepted words do not change the lag. The delay of each tap is counted in accepted words only, however far apart the words arrive.
- R5: While `rst_n` is low on a rising edge, `tap_bus` and `tail_data` become zero and the word count restarts at 0, even if `in_valid` is high. Stored words are not cleared.
- R6: A configuration is legal only if W >= 1, M >= 2, N >= 1, W*M*N <= 4608 and N*W <= 36. The package function `mts_fits` reports legality. An illegal configuration stops elaboration with an error.
- R7: Take two instances sharing `in_valid`, with the second fed from the first's `tail_data`. After word s is accepted, the second instance's tap k equals word s-(N+k)*M-1. This holds whenever that index is >= 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of pointer and tap registers |
| in_valid | input | 1 | Accept `in_data` on this edge and shift every stage |
| in_data | input | W | Incoming word |
| tap_bus | output | N*W | All taps side by side, tap 1 in the lowest W bits |
| tail_data | output | W | Deepest tap (tap N), for cascading |

## Verification
The pointer and lane properties need `rst_n` low for at least one edge at the start of the run. They also need `in_valid` to be a known 0 or 1 on every edge after that, because it alone decides whether pointer, memory and taps move. The stimulus starts in reset and drives `in_valid`, `in_data` and `rst_n` only at the falling clock edge, always with defined values. It mixes random valid gaps with bursts, long idles and a reset in mid-stream. Tap values are compared only once the lanes ahead of them have filled.

// File: rtl/mts_pkg.sv
package mts_pkg;
  localparam int unsigned MTS_MAX_BITS     = 4608;
  localparam int unsigned MTS_MAX_TAP_BITS = 36;

  // R6: legality of a configuration (width, spacing, tap count)
  function automatic bit mts_fits(input int unsigned w, input int unsigned m,
                                  input int unsigned n);
    return (w >= 1) && (m >= 2) && (n >= 1) &&
           (w * m * n <= MTS_MAX_BITS) && (n * w <= MTS_MAX_TAP_BITS);
  endfunction
endpackage

// File: rtl/mts_ring_ptr.sv
module mts_ring_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (step)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // R4: one position per accepted word, wrapping after DEPTH positions
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr == LAST) |=> ptr == '0);
  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
  // R3: idle edges leave the pointer alone
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr));
endmodule

// File: rtl/mts_lane.sv
module mts_lane #(
  parameter int unsigned W  = 8,
  parameter int unsigned M  = 16,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  q
);
  logic [W-1:0] store [M];

  // read-first: the oldest word leaves while the new one takes its slot
  assign rdata = store[addr];

  always_ff @(posedge clk) begin
    if (shift) store[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (shift)  q <= rdata;
  end

  // R3: the tap register moves only on a shift
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(q));
endmodule

// File: rtl/mem_tap_shifter.sv
module mem_tap_shifter #(
  parameter int unsigned W = 8,
  parameter int unsigned M = 16,
  parameter int unsigned N = 4,
  localparam int unsigned AW = (M > 1) ? $clog2(M) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_data,
  output logic [N*W-1:0] tap_bus,
  output logic [W-1:0]   tail_data
);
  // R6: reject configurations beyond storage or tap-width limits
  if (!mts_pkg::mts_fits(W, M, N)) begin : g_bad_cfg
    $error("mem_tap_shifter: W*M*N or N*W exceeds the allowed limit");
  end

  logic [AW-1:0] ptr;
  logic [W-1:0]  rd [N];
  logic [W-1:0]  q  [N];
  logic [W-1:0]  wd [N];

  mts_ring_ptr #(.DEPTH(M)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(in_valid), .ptr(ptr)
  );

  for (genvar j = 0; j < N; j++) begin : g_lane
    if (j == 0) begin : g_head
      assign wd[j] = in_data;
    end else begin : g_body
      assign wd[j] = rd[j-1];
      // R1: lane j stores exactly what lane j-1 handed out on the same shift
      p_link_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> q[j-1] == $past(wd[j]));
    end

    mts_lane #(.W(W), .M(M), .AW(AW)) u_lane (
      .clk(clk), .rst_n(rst_n), .shift(in_valid), .addr(ptr),
      .wdata(wd[j]), .rdata(rd[j]), .q(q[j])
    );

    assign tap_bus[j*W +: W] = q[j];
  end

  assign tail_data = q[N-1];
endmodule

// File: tb/tb_mem_tap_shifter.sv
module tb_mem_tap_shifter;
  localparam int W = 8, M = 16, N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [N*W-1:0] tap_bus, tap_bus_b;
  logic [W-1:0] tail_data, tail_b;

  always #4 clk = ~clk;

  mem_tap_shifter #(.W(W), .M(M), .N(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .tap_bus(tap_bus), .tail_data(tail_data));
  mem_tap_shifter #(.W(W), .M(M), .N(N)) dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(tail_data),
    .tap_bus(tap_bus_b), .tail_data(tail_b));

  int total = 0, bad = 0;
  logic [W-1:0] hist [0:8191];
  int cnt = 0;
  int gap = 0;
  logic [N*W-1:0] prev_a = '0, prev_b = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] seg(input logic [N*W-1:0] bus, input int k);
    return bus[(k-1)*W +: W];
  endfunction

  task automatic verify(input bit v);
    int s;
    s = cnt - 1;
    chk(tail_data == seg(tap_bus, N), "R2", tail_data, seg(tap_bus, N));
    if (v) begin
      for (int k = 1; k <= N; k++) begin
        if (s >= k*M)
          chk(seg(tap_bus, k) == hist[s-k*M], (gap > 0) ? "R4" : "R1",
              seg(tap_bus, k), hist[s-k*M]);
        if (s - (N+k)*M - 1 >= 0)
          chk(seg(tap_bus_b, k) == hist[s-(N+k)*M-1], "R7",
              seg(tap_bus_b, k), hist[s-(N+k)*M-1]);
      end
      gap = 0;
    end else begin
      chk(tap_bus == prev_a, "R3", tap_bus, prev_a);
      chk(tap_bus_b == prev_b, "R3", tap_bus_b, prev_b);
      gap++;
    end
    prev_a = tap_bus;
    prev_b = tap_bus_b;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cycle(input bit v, input logic [W-1:0] d);
    in_valid = v;
    in_data  = d;
    @(posedge clk);
    if (v) begin hist[cnt] = d; cnt++; end
    @(negedge clk);
    verify(v);
  endtask

  task automatic do_reset(input int len);
    rst_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data = W'($urandom);
      @(posedge clk);
      @(negedge clk);
      chk(tap_bus == '0, "R5", tap_bus, 0);
      chk(tail_data == '0, "R5", tail_data, 0);
    end
    rst_n = 1'b1;
    in_valid = 1'b0;
    cnt = 0; gap = 0; prev_a = '0; prev_b = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R6: legality limits at their boundaries
    chk(mts_pkg::mts_fits(8, 16, 4) == 1'b1, "R6", 0, 1);
    chk(mts_pkg::mts_fits(4, 288, 4) == 1'b1, "R6", 0, 1);
    chk(mts_pkg::mts_fits(4, 289, 4) == 1'b0, "R6", 1, 0);
    chk(mts_pkg::mts_fits(12, 2, 3) == 1'b1, "R6", 0, 1);
    chk(mts_pkg::mts_fits(37, 2, 1) == 1'b0, "R6", 1, 0);
    chk(mts_pkg::mts_fits(8, 1, 2) == 1'b0, "R6", 1, 0);

    @(negedge clk);
    do_reset(3);
    // back-to-back burst
    for (int i = 0; i < 300; i++) cycle(1'b1, W'($urandom));
    // directed patterns
    for (int i = 0; i < 2*M; i++) cycle(1'b1, (i % 2) ? 8'hFF : 8'h00);
    for (int i = 0; i < 2*M; i++) cycle(1'b1, 8'hA5 ^ W'(i));
    // long idle, then resume
    for (int i = 0; i < 60; i++) cycle(1'b0, W'($urandom));
    for (int i = 0; i < 40; i++) cycle(1'b1, W'($urandom));
    // random gaps
    for (int i = 0; i < 1500; i++) cycle(($urandom % 10) < 6, W'($urandom));
    // mid-stream reset with valid high, then refill
    do_reset(2);
    for (int i = 0; i < 800; i++) cycle(($urandom % 4) != 0, W'($urandom));
    for (int i = 0; i < 20; i++) cycle(1'b0, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule